// File: doc/BRIEF.md
# External Memory Bus Event Interrupt Collector

This block gathers the interrupt sources of an external memory bus controller into one registered interrupt line. Two sources come from the flash engine inside the controller: a buffer-threshold event and a transfer-count-reached event. Both are synchronous to the block clock. The other sources are a parameterised number of external wait pins. Each wait pin passes through a two-flop synchroniser. It then raises its own event on a rising edge or a falling edge, and software picks which edge for each pin.

Every event sets a sticky status bit that software clears by writing a 1 to it. Each status bit has an enable bit, and the interrupt output is the registered OR of the enabled status bits. A small register port also returns the synchronised pin levels, so software can use the wait pins as plain general-purpose inputs.

Top module: `extmem_evt_irq`

## Requirements
- R1: After reset, the status, enable and polarity registers all read 0 and `irq` is 0.
- R2: Event numbering is fixed. Status bit 0 is the flash buffer event (`fifo_evt`). Bit 1 is the transfer-count event (`tcount_evt`). Bit 2+n is the edge event of wait pin n.
- R3: When polarity bit n is 0, a 0-to-1 transition of synchronised pin n sets status bit 2+n. A 1-to-0 transition of that pin sets nothing.
- R4: When polarity bit n is 1, a 1-to-0 transition of synchronised pin n sets status bit 2+n. A 0-to-1 transition of that pin sets nothing.
- R5: Status bits are sticky. Writing to address 0 clears each bit where `wr_data` holds a 1 and leaves each bit where it holds a 0.
- R6: A clear of a status bit is overridden by a new event on the same bit in the same cycle: the bit stays 1.
- R7: `irq` equals the OR over all bits of status AND enable, as the two registers stood one clock earlier.
- R8: Address 3 reads the synchronised pin levels, with bit n being wait pin n. A pin change first appears there after two clocks of synchronisation.
- R9: The register addresses are 0 = status (write 1 to clear), 1 = enable (2+NUM_WAIT bits), 2 = polarity (NUM_WAIT bits) and 3 = pin levels (read only). `rd_data` is registered and shows the addressed register one clock after `addr` is applied. Bits above a register's width read 0.
- R10: Changing a polarity bit while the pin is steady raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_evt | input | 1 | Flash buffer event, one clock per event |
| tcount_evt | input | 1 | Flash transfer-count event, one clock per event |
| wait_pin | input | NUM_WAIT | Asynchronous external wait pins |
| addr | input | 2 | Register select for both read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
The assertions check four things on every cycle. Each edge event matches the selected polarity and a real change of the synchronised level. Status bits hold unless cleared. An event always wins over a clear. `irq` follows the enabled status of the previous cycle. Only the bench scenarios can show the rest:
- the fixed mapping from sources to bit positions;
- the two-clock delay of the pin readback;
- the zero-filled upper read bits;
- the absence of events after polarity changes or on the unselected edge, seen through the status register.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ENGINE_EVTS = 2;
  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_ENABLE = 2'd1;
  localparam logic [1:0] SEL_POL    = 2'd2;
  localparam logic [1:0] SEL_LEVEL  = 2'd3;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/evt_edge.sv
module evt_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign hit[g] = pol[g] ? (prev_q[g] & ~lvl[g]) : (lvl[g] & ~prev_q[g]);

    // R3 R4 R10
    edge_pol_chk: assert property (@(posedge clk) disable iff (rst)
      hit[g] |-> (lvl[g] == !pol[g]) && (lvl[g] != $past(lvl[g])));
  end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  parameter int DATA_W   = 16,
  localparam int NUM_EVT = ENGINE_EVTS + NUM_WAIT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EVT-1:0]  set_vec,
  input  logic [NUM_WAIT-1:0] lvl,
  input  logic [1:0]          addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_WAIT-1:0] pol,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  logic [NUM_EVT-1:0]  status_q, en_q, clr;
  logic [NUM_WAIT-1:0] pol_q;
  logic [DATA_W-1:0]   rd_n;
  logic                unused_wr;

  assign unused_wr = ^wr_data;
  assign clr = (wr_en && addr == SEL_STATUS) ? wr_data[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      en_q     <= '0;
      pol_q    <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | set_vec;
      if (wr_en && addr == SEL_ENABLE) en_q  <= wr_data[NUM_EVT-1:0];
      if (wr_en && addr == SEL_POL)    pol_q <= wr_data[NUM_WAIT-1:0];
      irq <= |(status_q & en_q);
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      SEL_STATUS: rd_n[NUM_EVT-1:0]  = status_q;
      SEL_ENABLE: rd_n[NUM_EVT-1:0]  = en_q;
      SEL_POL:    rd_n[NUM_WAIT-1:0] = pol_q;
      default:    rd_n[NUM_WAIT-1:0] = lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  assign pol = pol_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[g] && !clr[g]) |=> status_q[g]);
    // R5
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[g] && clr[g] && !set_vec[g]) |=> !status_q[g]);
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_vec[g] |=> status_q[g]);
  end

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |($past(status_q & en_q)));
endmodule

// File: rtl/extmem_evt_irq.sv
module extmem_evt_irq
  import evt_pkg::*;
#(
  parameter int NUM_WAIT    = 2,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_evt,
  input  logic                tcount_evt,
  input  logic [NUM_WAIT-1:0] wait_pin,
  input  logic [1:0]          addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  localparam int NUM_EVT = ENGINE_EVTS + NUM_WAIT;

  logic [NUM_WAIT-1:0] lvl, pol, hit;
  logic [NUM_EVT-1:0]  set_vec;

  evt_sync #(.W(NUM_WAIT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(wait_pin), .dout(lvl)
  );

  evt_edge #(.W(NUM_WAIT)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .pol(pol), .hit(hit)
  );

  assign set_vec = {hit, tcount_evt, fifo_evt};

  evt_regs #(.NUM_WAIT(NUM_WAIT), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .set_vec(set_vec), .lvl(lvl), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .pol(pol), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: tb/extmem_evt_irq_tb.sv
module extmem_evt_irq_tb;
  localparam int NW = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_evt = 1'b0, tcount_evt = 1'b0;
  logic [NW-1:0] wait_pin = '0;
  logic [1:0]    addr = 2'd0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  extmem_evt_irq #(.NUM_WAIT(NW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .fifo_evt(fifo_evt), .tcount_evt(tcount_evt),
    .wait_pin(wait_pin), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // Vector layout: {polarity[1:0], pins_before[1:0], pins_after[1:0], expected_status[3:0]}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 2'b00, 2'b01, 4'b0100},
    {2'b00, 2'b00, 2'b10, 4'b1000},
    {2'b00, 2'b11, 2'b00, 4'b0000},
    {2'b11, 2'b11, 2'b00, 4'b1100},
    {2'b01, 2'b00, 2'b11, 4'b1000},
    {2'b10, 2'b11, 2'b01, 4'b1000},
    {2'b01, 2'b11, 2'b10, 4'b0100},
    {2'b00, 2'b01, 2'b01, 4'b0000}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(2'd0, v); check("R1 status", v, 16'h0);
    rd(2'd1, v); check("R1 enable", v, 16'h0);
    rd(2'd2, v); check("R1 polarity", v, 16'h0);

    // R3 R4 R10: table of pin scenarios
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, {14'd0, VEC[k][9:8]});
      wait_pin = VEC[k][7:6];
      idle(4);
      wr(2'd0, 16'h000F);
      wait_pin = VEC[k][5:4];
      idle(5);
      rd(2'd0, v);
      check($sformatf("R3 R4 R10 vector %0d", k), v, {12'd0, VEC[k][3:0]});
    end
    wait_pin = '0;
    wr(2'd2, 16'h0);
    idle(4);
    wr(2'd0, 16'h000F);

    // R2 engine events map to bits 0 and 1
    @(negedge clk); fifo_evt = 1'b1;
    @(negedge clk); fifo_evt = 1'b0;
    rd(2'd0, v); check("R2 fifo bit0", v, 16'h0001);
    @(negedge clk); tcount_evt = 1'b1;
    @(negedge clk); tcount_evt = 1'b0;
    rd(2'd0, v); check("R2 tcount bit1", v, 16'h0003);

    // R5 write-one-to-clear
    wr(2'd0, 16'h0000); rd(2'd0, v); check("R5 zero write keeps", v, 16'h0003);
    wr(2'd0, 16'h0001); rd(2'd0, v); check("R5 clear bit0", v, 16'h0002);

    // R7 irq masking and one-cycle registration
    check("R7 disabled irq", {15'd0, irq}, 16'd0);
    @(negedge clk); addr = 2'd1; wr_data = 16'h0002; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R7 irq delay", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R7 irq set", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'h0002);
    @(negedge clk);
    check("R7 irq drop", {15'd0, irq}, 16'd0);

    // R6 event beats clear in same cycle
    @(negedge clk); fifo_evt = 1'b1; addr = 2'd0; wr_data = 16'h0001; wr_en = 1'b1;
    @(negedge clk); fifo_evt = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); check("R6 set wins", v, 16'h0001);
    wr(2'd0, 16'h000F);

    // R9 unused upper bits read zero
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R9 enable width", v, 16'h000F);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); check("R9 polarity width", v, 16'h0003);
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0000);

    // R8 level readback with synchroniser delay
    rd(2'd3, v); check("R8 level idle", v, 16'h0000);
    @(negedge clk); wait_pin = 2'b10; addr = 2'd3;
    @(negedge clk);
    @(negedge clk); check("R8 level early", rd_data, 16'h0000);
    idle(2);
    check("R8 level settled", rd_data, 16'h0002);
    wr(2'd0, 16'h000F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule